// File: doc/BRIEF.md
# Index and Memory Modify Unit

This block carries out the modify-index operation of a 16-bit machine that has three index registers and an instruction address register (IAR). Given one instruction word and, for long format, its second word, it adds a signed amount to one target and writes the sum back. The target is the IAR, one of the index registers, or a word in memory. The format bit and the index-register field of the instruction pick the target. After the update it works out the next IAR. That is either the next sequential word, the word after it (a skip), or a branch target.

The surrounding core supplies several inputs. It gives the address of the next sequential instruction word, already past any second word. It also gives the current index register values as one packed bus. In return it applies the write strobes the unit raises. For the memory variant the unit drives a synchronous memory port: a read request returns data on the following cycle, then the unit issues a write. All operands are captured on the cycle `start_i` is accepted. `start_i` is ignored while an operation is in flight.

Top module: `mdx_unit`

## Requirements
- R1: Instruction fields are decoded as follows. Bit 10 set means long format. Bits 9:8 select the index register: 0 means none and 1 to 3 mean registers one to three. Bits 7:0 are a signed displacement from -128 to +127. Bits 15:11 are ignored.
- R2: Short format with field 0 writes next_addr + displacement into the IAR as a branch. It never skips, even when the result is zero or has a different sign. It writes no index register and no memory.
- R3: Short format with field n writes XRn + displacement back to XRn.
- R4: Long format with field n writes XRn + second word (the full 16 bits) back to XRn.
- R5: Long format with field 0 reads memory at the address given by the second word, in the cycle after start. It writes the old value + displacement to the same address two cycles later. It raises done on the cycle after that write.
- R6: For every variant except R2, let old be the value before the update. If the result is zero, or its bit 15 differs from old bit 15, the IAR becomes next_addr + 1 and skip_o is high. Otherwise the IAR becomes next_addr.
- R7: All sums wrap modulo 2^16.
- R8: Register and IAR variants finish in the cycle after start is accepted. Every operation ends with exactly one cycle in which done_o and iar_we_o are high. mem_re_o, mem_we_o and done_o are never high together.
- R9: A start that arrives while an operation is in progress is ignored. The running operation completes unchanged and no second operation follows.
- R10: After reset the unit is idle with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| instr_i | input | 16 | Instruction word |
| word2_i | input | 16 | Second word (long format) |
| next_addr_i | input | 16 | Address of next sequential instruction |
| xr_i | input | 48 | Index registers, XRn at bits 16n-1:16(n-1) |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after a read |
| done_o | output | 1 | Operation complete |
| skip_o | output | 1 | Next word is skipped (valid with done) |
| iar_we_o | output | 1 | IAR write strobe |
| iar_wdata_o | output | 16 | New IAR value |
| xr_we_o | output | 1 | Index register write strobe |
| xr_sel_o | output | 2 | Index register written (1 to 3) |
| xr_wdata_o | output | 16 | Index register write data |
| mem_re_o | output | 1 | Memory read request |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |

## Verification
The assertions check several orderings on every cycle. A memory write always comes two cycles after a read, and done follows the write. The three strobes never overlap. An index write names a real register. The plain IAR variant never skips, and a skip always loads next_addr + 1.

Only the bench scenarios can show the arithmetic itself. They cover the wrap of sums, and a zero or sign-flipped result that triggers a skip while a same-sign negative result does not. They also show the branch variant staying silent at zero and at a sign change, and a repeated start being dropped during a memory operation.

// File: rtl/mdx_pkg.sv
// Shared types for the modify-index unit.
// Assumes the four variants and the controller states listed here cover all operations.
package mdx_pkg;
    typedef enum logic [1:0] {
        VAR_IAR      = 2'd0,
        VAR_XR_SHORT = 2'd1,
        VAR_XR_LONG  = 2'd2,
        VAR_MEM      = 2'd3
    } mdx_var_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_EXEC = 3'd1,
        ST_RD   = 3'd2,
        ST_ADD  = 3'd3,
        ST_WR   = 3'd4,
        ST_FIN  = 3'd5
    } mdx_state_e;
endpackage

// File: rtl/mdx_decode.sv
// Splits an instruction word into format, index selector and sign-extended
// displacement, and classifies the operation variant.
// Assumes the long-format flag sits just above the selector field, which
// sits just above the displacement; opcode bits above are ignored.
module mdx_decode
    import mdx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic [DATA_W-1:0] instr_i,
    output logic              long_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] disp_o,
    output mdx_var_e          variant_o
);
    localparam int SEL_LSB  = DISP_W;
    localparam int LONG_BIT = DISP_W + SEL_W;

    logic unused_opcode;

    // Field extraction and sign extension of the displacement.
    always_comb begin
        long_o = instr_i[LONG_BIT];
        sel_o  = instr_i[SEL_LSB +: SEL_W];
        disp_o = {{(DATA_W-DISP_W){instr_i[DISP_W-1]}}, instr_i[DISP_W-1:0]};
    end

    assign unused_opcode = ^instr_i[DATA_W-1:LONG_BIT+1];

    // Variant selection from format and selector.
    always_comb begin
        if (long_o) begin
            variant_o = (sel_o == '0) ? VAR_MEM : VAR_XR_LONG;
        end else begin
            variant_o = (sel_o == '0) ? VAR_IAR : VAR_XR_SHORT;
        end
    end
endmodule

// File: rtl/mdx_addskip.sv
// Wrapping adder with the zero-or-sign-change skip test.
// Assumes two's complement operands of equal width; no carry or overflow out.
module mdx_addskip #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] addend_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              skip_o
);
    // Modulo 2^DATA_W sum and skip decision from old and new sign.
    always_comb begin
        sum_o  = old_i + addend_i;
        skip_o = (sum_o == '0) || (sum_o[DATA_W-1] != old_i[DATA_W-1]);
    end
endmodule

// File: rtl/mdx_ctrl.sv
// Sequencer: one execute cycle for register and IAR variants,
// read / add / write / finish for the memory variant.
// Assumes start is only honoured in the idle state.
module mdx_ctrl
    import mdx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  mdx_var_e   variant_i,
    output mdx_state_e state_o,
    output logic       accept_o
);
    mdx_state_e state_d;

    assign accept_o = (state_o == ST_IDLE) && start_i;

    // Next-state selection.
    always_comb begin
        state_d = state_o;
        unique case (state_o)
            ST_IDLE: if (start_i) state_d = (variant_i == VAR_MEM) ? ST_RD : ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            ST_RD:   state_d = ST_ADD;
            ST_ADD:  state_d = ST_WR;
            ST_WR:   state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= state_d;
    end

    // R9: a running memory operation is not diverted by a new start.
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RD) |=> (state_o == ST_ADD));
    // R8: the execute cycle always returns to idle.
    assert_exec_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_EXEC) |=> (state_o == ST_IDLE));
endmodule

// File: rtl/mdx_unit.sv
// Top of the modify-index unit: captures operands on start, selects the
// target and addend, runs the shared adder and drives the write strobes.
// Assumes the environment applies xr/IAR writes at the clock edge after the
// strobe and that memory read data is valid one cycle after mem_re_o.
module mdx_unit
    import mdx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8,
    parameter int SEL_W  = 2,
    parameter int NUM_XR = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [DATA_W-1:0]        instr_i,
    input  logic [DATA_W-1:0]        word2_i,
    input  logic [DATA_W-1:0]        next_addr_i,
    input  logic [DATA_W*NUM_XR-1:0] xr_i,
    input  logic [DATA_W-1:0]        mem_rdata_i,
    output logic                     done_o,
    output logic                     skip_o,
    output logic                     iar_we_o,
    output logic [DATA_W-1:0]        iar_wdata_o,
    output logic                     xr_we_o,
    output logic [SEL_W-1:0]         xr_sel_o,
    output logic [DATA_W-1:0]        xr_wdata_o,
    output logic                     mem_re_o,
    output logic                     mem_we_o,
    output logic [DATA_W-1:0]        mem_addr_o,
    output logic [DATA_W-1:0]        mem_wdata_o
);
    localparam int SEL_N = 1 << SEL_W;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic              dec_long;
    logic [SEL_W-1:0]  dec_sel;
    logic [DATA_W-1:0] dec_disp;
    mdx_var_e          dec_var;
    mdx_state_e        state;
    logic              accept;

    logic [DATA_W-1:0] xr_arr [SEL_N];
    logic [DATA_W-1:0] xr_pick;

    mdx_var_e          var_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] old_q, addend_q, next_q, addr_q;
    logic [DATA_W-1:0] sum_q;
    logic              skip_q;

    logic [DATA_W-1:0] operand, sum;
    logic              raw_skip, final_skip;
    logic              unused_long;

    mdx_decode #(.DATA_W(DATA_W), .DISP_W(DISP_W), .SEL_W(SEL_W)) u_decode (
        .instr_i   (instr_i),
        .long_o    (dec_long),
        .sel_o     (dec_sel),
        .disp_o    (dec_disp),
        .variant_o (dec_var)
    );

    assign unused_long = dec_long;

    mdx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .variant_i (dec_var),
        .state_o   (state),
        .accept_o  (accept)
    );

    // Unpack the index register bus; selector 0 and absent registers read zero.
    for (genvar g = 0; g < SEL_N; g++) begin : g_xr
        if (g >= 1 && g <= NUM_XR) begin : g_real
            assign xr_arr[g] = xr_i[DATA_W*(g-1) +: DATA_W];
        end else begin : g_none
            assign xr_arr[g] = '0;
        end
    end

    assign xr_pick = xr_arr[dec_sel];

    // Operand capture when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            var_q    <= VAR_IAR;
            sel_q    <= '0;
            old_q    <= '0;
            addend_q <= '0;
            next_q   <= '0;
            addr_q   <= '0;
        end else if (accept) begin
            var_q    <= dec_var;
            sel_q    <= dec_sel;
            old_q    <= (dec_var == VAR_IAR) ? next_addr_i : xr_pick;
            addend_q <= (dec_var == VAR_XR_LONG) ? word2_i : dec_disp;
            next_q   <= next_addr_i;
            addr_q   <= word2_i;
        end
    end

    // Memory data replaces the captured operand during the add cycle.
    assign operand = (state == ST_ADD) ? mem_rdata_i : old_q;

    mdx_addskip #(.DATA_W(DATA_W)) u_add (
        .old_i    (operand),
        .addend_i (addend_q),
        .sum_o    (sum),
        .skip_o   (raw_skip)
    );

    // Hold the memory-variant result across the write and finish cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            skip_q <= 1'b0;
        end else if (state == ST_ADD) begin
            sum_q  <= sum;
            skip_q <= raw_skip;
        end
    end

    // Output strobes and data.
    always_comb begin
        done_o      = (state == ST_EXEC) || (state == ST_FIN);
        final_skip  = (state == ST_EXEC) ? ((var_q != VAR_IAR) && raw_skip) : skip_q;
        skip_o      = done_o && final_skip;
        iar_we_o    = done_o;
        if ((state == ST_EXEC) && (var_q == VAR_IAR)) iar_wdata_o = sum;
        else if (final_skip)                          iar_wdata_o = next_q + ONE;
        else                                          iar_wdata_o = next_q;
        xr_we_o     = (state == ST_EXEC) && (var_q != VAR_IAR);
        xr_sel_o    = sel_q;
        xr_wdata_o  = sum;
        mem_re_o    = (state == ST_RD);
        mem_we_o    = (state == ST_WR);
        mem_addr_o  = addr_q;
        mem_wdata_o = sum_q;
    end

    // R2: the plain IAR branch never reports a skip.
    assert_iar_branch_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && var_q == VAR_IAR) |-> !skip_o);
    // R3: an index write always names a real register and completes the operation.
    assert_xr_write_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xr_we_o |-> (done_o && xr_sel_o != '0));
    // R5: a memory write comes two cycles after its read.
    assert_mem_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_re_o, 2));
    // R5: memory variant completes the cycle after the write.
    assert_mem_done_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && var_q == VAR_MEM) |-> $past(mem_we_o));
    // R6: a skip always loads the word after the next sequential one.
    assert_skip_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (iar_we_o && iar_wdata_o == next_q + ONE));
    // R8: strobes are mutually exclusive.
    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re_o, mem_we_o, done_o}));
endmodule

// File: tb/tb_mdx_unit.sv
`timescale 1ns/1ps
module tb_mdx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] instr_i = '0, word2_i = '0, next_addr_i = '0;
    logic [15:0] mem_rdata_i = '0;
    logic [47:0] xr_i;
    logic        done_o, skip_o, iar_we_o, xr_we_o, mem_re_o, mem_we_o;
    logic [1:0]  xr_sel_o;
    logic [15:0] iar_wdata_o, xr_wdata_o, mem_addr_o, mem_wdata_o;

    logic [15:0] xr [0:3];
    logic [15:0] mem [0:255];
    int n_checks = 0, n_pass = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign xr_i = {xr[3], xr[2], xr[1]};

    mdx_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .word2_i(word2_i), .next_addr_i(next_addr_i), .xr_i(xr_i),
        .mem_rdata_i(mem_rdata_i), .done_o(done_o), .skip_o(skip_o),
        .iar_we_o(iar_we_o), .iar_wdata_o(iar_wdata_o), .xr_we_o(xr_we_o),
        .xr_sel_o(xr_sel_o), .xr_wdata_o(xr_wdata_o), .mem_re_o(mem_re_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    // Environment model: register file and synchronous memory respond to strobes.
    always @(posedge clk) begin
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
        if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        if (xr_we_o)  xr[xr_sel_o] <= xr_wdata_o;
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act === exp) n_pass++;
        else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    // Strobe vector order: {mem_re, mem_we, done, iar_we, xr_we}
    function automatic logic [15:0] strobes();
        return {11'd0, mem_re_o, mem_we_o, done_o, iar_we_o, xr_we_o};
    endfunction

    function automatic logic [15:0] mk(input bit lng, input logic [1:0] sel, input logic [7:0] d);
        return {5'b10101, lng, sel, d};
    endfunction

    task automatic run_op(input logic [15:0] ins, input logic [15:0] w2, input logic [15:0] nxt,
                          input bit dup, input string req);
        bit lng = ins[10];
        logic [1:0] sel = ins[9:8];
        logic [15:0] d = {{8{ins[7]}}, ins[7:0]};
        logic [15:0] old, add, sum, exp_iar;
        bit skp;
        if (!lng && sel == 0) begin old = nxt; add = d; end
        else if (sel != 0)    begin old = xr[sel]; add = lng ? w2 : d; end
        else                  begin old = mem[w2[7:0]]; add = d; end
        sum = 16'((int'(old) + int'(add)) % 65536);
        if (!lng && sel == 0) begin skp = 0; exp_iar = sum; end
        else begin
            skp = (sum == 0) || (sum[15] != old[15]);
            exp_iar = skp ? 16'(nxt + 1) : nxt;
        end
        instr_i = ins; word2_i = w2; next_addr_i = nxt; start_i = 1'b1;
        @(negedge clk);
        if (lng && sel == 0) begin
            chk(req, "read strobes", strobes(), 16'b10000);
            chk(req, "read addr", mem_addr_o, w2);
            if (dup) instr_i = mk(0, 2'd1, 8'h01);
            else     start_i = 1'b0;
            @(negedge clk);
            start_i = 1'b0;
            chk(req, "add strobes", strobes(), 16'b00000);
            @(negedge clk);
            chk(req, "write strobes", strobes(), 16'b01000);
            chk(req, "write addr", mem_addr_o, w2);
            chk(req, "write data", mem_wdata_o, sum);
            @(negedge clk);
            chk(req, "done strobes", strobes(), 16'b00110);
            chk(req, "skip", {15'd0, skip_o}, {15'd0, skp});
            chk(req, "iar", iar_wdata_o, exp_iar);
        end else begin
            start_i = 1'b0;
            chk(req, "done strobes", strobes(), {11'd0, 3'b001, 1'b1, sel != 0});
            chk(req, "skip", {15'd0, skip_o}, {15'd0, skp});
            chk(req, "iar", iar_wdata_o, exp_iar);
            if (sel != 0) begin
                chk(req, "xr sel", {14'd0, xr_sel_o}, {14'd0, sel});
                chk(req, "xr data", xr_wdata_o, sum);
            end
        end
        @(negedge clk);
        chk(req, "idle after op", strobes(), 16'b00000);
    endtask

    initial begin
        xr[0] = 16'h0000; xr[1] = 16'h0010; xr[2] = 16'h0003; xr[3] = 16'h0001;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
        mem[8'h20] = 16'h0100; mem[8'h21] = 16'h0001; mem[8'h22] = 16'h7FFF;
        repeat (3) @(negedge clk);
        chk("R10", "reset strobes", strobes(), 16'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle strobes", strobes(), 16'b00000);
        run_op(mk(0, 0, 8'h05), 16'h0000, 16'h0100, 0, "R2 R1");
        run_op(mk(0, 0, 8'h80), 16'h0000, 16'h0080, 0, "R2 zero no skip");
        run_op(mk(0, 0, 8'hFD), 16'h0000, 16'h0002, 0, "R2 R7 sign flip no skip");
        run_op(mk(0, 1, 8'h03), 16'h0000, 16'h0200, 0, "R3");
        run_op(mk(0, 2, 8'hFD), 16'h0000, 16'h0210, 0, "R3 R6 zero");
        run_op(mk(0, 3, 8'hFE), 16'h0000, 16'h0220, 0, "R6 sign change");
        run_op(mk(1, 1, 8'h00), 16'h7FF0, 16'h0300, 0, "R4 R6");
        run_op(mk(1, 2, 8'h55), 16'h1234, 16'h0310, 0, "R4 R1 disp unused");
        run_op(mk(1, 3, 8'h00), 16'h0001, 16'h0320, 0, "R4 R7 wrap");
        run_op(mk(0, 1, 8'hFD), 16'h0000, 16'h0330, 0, "R6 negative same sign");
        run_op(mk(1, 0, 8'h01), 16'h0020, 16'h0400, 0, "R5");
        run_op(mk(1, 0, 8'hFF), 16'h0021, 16'h0410, 0, "R5 R6 zero");
        run_op(mk(1, 0, 8'h01), 16'h0022, 16'h0420, 1, "R9 R5 R8");
        @(negedge clk);
        chk("R5", "memory word stored", mem[8'h22], 16'h8000);
        chk("R3", "register file value", xr[1], 16'h8000);
        finished = 1;
        $display("%0d/%0d checks passed", n_pass, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_pass, n_checks);
            $finish;
        end
    end
endmodule